// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

This block is a watchdog counter that software must service on a regular schedule. It counts slow clock ticks, which arrive as a one-cycle enable on the `tick` input and are nominally 32 kHz. It counts down from a programmed length. When software fails to service it in time, it either raises an interrupt or drives a reset pulse.

Four write-protected registers on a simple 32-bit write/read port control it:

- a control word at offset 0x00,
- a timeout length at 0x04,
- a service ("kick") location at 0x08,
- an immediate-reset location at 0x14.

Each write must carry a magic value, or the block ignores it. A two-stage mode raises the interrupt first and gives the system one more timeout period before it resets. An external reset pin mirrors the reset pulse, and its active level is programmable.

Top module: `kwdt_top`

## Requirements
- R1: A write to offset 0x00 is accepted only when wdata[31:24] is 0x22; any other write leaves the control word unchanged. Field positions: bit0 enable, bit1 pin polarity (1 = active high), bit2 pin enable, bit3 interrupt enable, bit4 auto-restart, bit6 two-stage, bit8 counter select. Reading 0x00 returns these bits, with every other bit read as zero.
- R2: A write to offset 0x04 is accepted only when wdata[4:0] is 0x08, and stores wdata[31:5] as the length field; a write without the key is ignored. A read returns the field in bits [31:5], with bits [4:0] zero.
- R3: Once the counter is loaded, the expiry falls exactly UNIT_TICKS × length ticks later, with UNIT_TICKS defaulting to 512. A length of 0 behaves as 1.
- R4: Writing exactly 0x1971 to offset 0x08 reloads the counter from the length field; any other value has no effect.
- R5: When the interrupt is disabled, an expiry raises `sys_rst` on the next cycle. `sys_rst` stays high for RST_TICKS ticks (default 16), after which the enable bit reads back 0 and the counter stays idle.
- R6: Writing exactly 0x1209 to offset 0x14 raises `sys_rst` on the cycle after the write, whether or not the counter is enabled, and produces the same RST_TICKS-long pulse. Any other value written there has no effect.
- R7: With the interrupt enabled and two-stage off, an expiry sets `irq` and produces no reset. `irq` stays high until a valid service write or until the enable bit is cleared.
- R8: With two-stage and interrupt both enabled, the first expiry sets `irq` and reloads the counter. A second expiry with no service write in between starts the reset pulse. A service write in between clears `irq` and returns the counter to the first stage.
- R9: Clearing the enable bit stops the count, so no expiry follows. Setting it again loads the full length.
- R10: While the reset pulse runs and the pin enable is set, `ext_rst` is at the active level given by the polarity bit. At all other times `ext_rst` holds the inactive level.
- R11: With auto-restart set, the enable bit stays 1 at the end of a reset pulse and the counter reloads from the length field.
- R12: The counter advances only on cycles where `tick` is high; with `tick` low it holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per slow tick |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data, including key bits |
| rd_data | output | 32 | Read data for `addr`, keys read as zero |
| irq | output | 1 | Pre-timeout interrupt, level |
| sys_rst | output | 1 | System reset pulse, active high |
| ext_rst | output | 1 | External reset pin, programmable level |

## Verification
The bench aims each timeout check at the exact cycle of expiry and at the cycle before it. A counter off by one prescaler step or one unit would fire a cycle early or late, and so would one that counts cycles instead of ticks. Writes that carry nearly correct keys or service values must leave the state untouched, which catches a decoder that checks too few bits. The bench also runs the service write between the two stages of two-stage mode, where a design that forgot to clear the stage would reset instead of re-raising the interrupt. It checks the end of the reset pulse with and without auto-restart, which shows up a pulse of the wrong length or an enable bit cleared in the wrong case.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int OFF_MODE    = 'h00;
    localparam int OFF_LEN     = 'h04;
    localparam int OFF_KICK    = 'h08;
    localparam int OFF_SWRST   = 'h14;

    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_VAL  = 32'h0000_1971;
    localparam logic [31:0] SWRST_VAL = 32'h0000_1209;

    typedef enum logic [1:0] {
        ST_WATCH  = 2'd0,
        ST_SECOND = 2'd1,
        ST_PULSE  = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic en;
        logic pol;
        logic pin_en;
        logic irq_en;
        logic auto_st;
        logic two_stage;
        logic cnt_sel;
    } mode_t;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              en_clr,
    output mode_t             mode,
    output logic [LEN_W-1:0]  len,
    output logic [31:0]       rd_data,
    output logic              kick_stb,
    output logic              swrst_stb,
    output logic              start_stb,
    output logic              stop_stb
);

    typedef struct packed {
        mode_t            mode;
        logic [LEN_W-1:0] len;
    } regs_s;

    regs_s r_q, r_d;

    logic sel_mode, sel_len, mode_ok, len_ok;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        sel_mode  = wr_en && (addr == ADDR_W'(OFF_MODE));
        sel_len   = wr_en && (addr == ADDR_W'(OFF_LEN));
        mode_ok   = sel_mode && (wdata[31:24] == MODE_KEY);
        len_ok    = sel_len && (wdata[4:0] == LEN_KEY);
        kick_stb  = wr_en && (addr == ADDR_W'(OFF_KICK)) && (wdata == KICK_VAL);
        swrst_stb = wr_en && (addr == ADDR_W'(OFF_SWRST)) && (wdata == SWRST_VAL);
        start_stb = mode_ok && wdata[0] && !r_q.mode.en;
        stop_stb  = mode_ok && !wdata[0] && r_q.mode.en;

        r_d = r_q;
        if (en_clr) begin
            r_d.mode.en = 1'b0;
        end
        if (mode_ok) begin
            r_d.mode.en        = wdata[0];
            r_d.mode.pol       = wdata[1];
            r_d.mode.pin_en    = wdata[2];
            r_d.mode.irq_en    = wdata[3];
            r_d.mode.auto_st   = wdata[4];
            r_d.mode.two_stage = wdata[6];
            r_d.mode.cnt_sel   = wdata[8];
        end
        if (len_ok) begin
            r_d.len = wdata[5 +: LEN_W];
        end

        rd_data = '0;
        if (addr == ADDR_W'(OFF_MODE)) begin
            rd_data = {23'd0, r_q.mode.cnt_sel, 1'b0, r_q.mode.two_stage, 1'b0,
                       r_q.mode.auto_st, r_q.mode.irq_en, r_q.mode.pin_en,
                       r_q.mode.pol, r_q.mode.en};
        end else if (addr == ADDR_W'(OFF_LEN)) begin
            rd_data[5 +: LEN_W] = r_q.len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode = r_q.mode;
    assign len  = r_q.len;

    p_mode_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode && (wdata[31:24] != MODE_KEY) && !en_clr) |=> $stable(r_q.mode));

    p_len_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_len && (wdata[4:0] != LEN_KEY)) |=> $stable(r_q.len));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int LEN_W      = 27,
    parameter int UNIT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             sw_load,
    input  logic             hw_load,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);

    localparam int PW = (UNIT_TICKS > 2) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(UNIT_TICKS - 1);

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [LEN_W-1:0] units;
    } cnt_s;

    cnt_s c_q, c_d;
    logic unit_edge, last_unit;

    always_comb begin
        unit_edge = tick && (c_q.presc == PRESC_LAST);
        last_unit = (c_q.units <= LEN_W'(1));
        expire    = run && !sw_load && unit_edge && last_unit;

        c_d = c_q;
        if (sw_load || hw_load) begin
            c_d.presc = '0;
            c_d.units = len;
        end else if (run && tick) begin
            if (c_q.presc == PRESC_LAST) begin
                c_d.presc = '0;
                if (!last_unit) begin
                    c_d.units = c_q.units - LEN_W'(1);
                end
            end else begin
                c_d.presc = c_q.presc + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_load && !hw_load) |=> ($stable(c_q.presc) && $stable(c_q.units)));

    p_expire_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (run && tick));

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
#(
    parameter int RST_TICKS = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  mode_t mode,
    input  logic  expire,
    input  logic  kick_stb,
    input  logic  swrst_stb,
    input  logic  stop_stb,
    output logic  run,
    output logic  reload,
    output logic  en_clr,
    output logic  sys_rst,
    output logic  irq
);

    localparam int PCW = $clog2(RST_TICKS + 1);
    localparam logic [PCW-1:0] PULSE_LAST = PCW'(RST_TICKS - 1);

    typedef struct packed {
        wd_state_e      st;
        logic           irq;
        logic [PCW-1:0] pcnt;
    } ctl_s;

    ctl_s s_q, s_d;
    logic fire, pulse_end;

    always_comb begin
        run       = mode.en && (s_q.st != ST_PULSE);
        fire      = expire && !stop_stb;
        pulse_end = (s_q.st == ST_PULSE) && tick && (s_q.pcnt == PULSE_LAST);
        reload    = 1'b0;
        en_clr    = 1'b0;
        s_d       = s_q;

        if (s_q.st == ST_PULSE) begin
            if (tick) begin
                s_d.pcnt = s_q.pcnt + PCW'(1);
            end
            if (pulse_end) begin
                s_d.st   = ST_WATCH;
                s_d.pcnt = '0;
                s_d.irq  = 1'b0;
                if (mode.auto_st) begin
                    reload = 1'b1;
                end else begin
                    en_clr = 1'b1;
                end
            end
        end else begin
            if (fire) begin
                if (mode.irq_en && (!mode.two_stage || (s_q.st == ST_WATCH))) begin
                    s_d.irq = 1'b1;
                    reload  = 1'b1;
                    s_d.st  = mode.two_stage ? ST_SECOND : ST_WATCH;
                end else begin
                    s_d.st   = ST_PULSE;
                    s_d.pcnt = '0;
                end
            end
            if (kick_stb || stop_stb) begin
                s_d.irq = 1'b0;
                s_d.st  = ST_WATCH;
            end
        end

        if (swrst_stb) begin
            s_d.st   = ST_PULSE;
            s_d.pcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_WATCH, irq: 1'b0, pcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_rst = (s_q.st == ST_PULSE);
    assign irq     = s_q.irq;

    p_swrst_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_stb |=> sys_rst);

    p_rst_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> ($past(expire) || $past(swrst_stb)));

    p_pulse_end_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> !irq);

    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mode.en);

    p_second_has_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_SECOND) |-> irq);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LEN_W      = 27,
    parameter int UNIT_TICKS = 512,
    parameter int RST_TICKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic              irq,
    output logic              sys_rst,
    output logic              ext_rst
);

    mode_t            mode;
    logic [LEN_W-1:0] len;
    logic kick_stb, swrst_stb, start_stb, stop_stb;
    logic en_clr, run, reload, expire;

    kwdt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .en_clr    (en_clr),
        .mode      (mode),
        .len       (len),
        .rd_data   (rd_data),
        .kick_stb  (kick_stb),
        .swrst_stb (swrst_stb),
        .start_stb (start_stb),
        .stop_stb  (stop_stb)
    );

    kwdt_counter #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .sw_load (kick_stb || start_stb),
        .hw_load (reload),
        .len     (len),
        .expire  (expire)
    );

    kwdt_ctrl #(.RST_TICKS(RST_TICKS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .expire    (expire),
        .kick_stb  (kick_stb),
        .swrst_stb (swrst_stb),
        .stop_stb  (stop_stb),
        .run       (run),
        .reload    (reload),
        .en_clr    (en_clr),
        .sys_rst   (sys_rst),
        .irq       (irq)
    );

    assign ext_rst = (sys_rst && mode.pin_en) ? mode.pol : !mode.pol;

    p_pin_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst |-> (ext_rst == !mode.pol));

endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;

    localparam int UNIT = 4;
    localparam int RSTT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq, sys_rst, ext_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    kwdt_top #(.UNIT_TICKS(UNIT), .RST_TICKS(RSTT)) u_kwdt_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq     (irq),
        .sys_rst (sys_rst),
        .ext_rst (ext_rst)
    );

    function automatic int tmo(input int l);
        return UNIT * ((l == 0) ? 1 : l);
    endfunction

    function automatic logic [31:0] mode_view(input logic [31:0] w);
        return w & 32'h0000_015F;
    endfunction

    function automatic logic [31:0] len_view(input logic [31:0] w);
        return w & 32'hFFFF_FFE0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, exp_mode, exp_len;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // reset state
        chk("R7 irq at reset", {31'd0, irq}, 32'd0);
        chk("R5 sys_rst at reset", {31'd0, sys_rst}, 32'd0);
        chk("R10 pin idle at reset", {31'd0, ext_rst}, 32'd1);
        rd(8'h00, v); chk("R1 mode at reset", v, 32'd0);
        rd(8'h04, v); chk("R2 length at reset", v, 32'd0);

        // R1 key protection, directed then random
        wr(8'h00, 32'h2300_015E);
        rd(8'h00, v); chk("R1 bad key ignored", v, 32'd0);
        wr(8'h00, 32'h22FF_FF5E);
        rd(8'h00, v); chk("R1 good key fields", v, 32'h0000_015E);
        exp_mode = 32'h0000_015E;
        for (int i = 0; i < 24; i++) begin
            logic ok;
            logic [7:0] k;
            ok = $urandom_range(0, 1) == 1;
            k  = ok ? 8'h22 : 8'h22 ^ 8'($urandom_range(1, 255));
            v  = {k, 24'($urandom()) & 24'hFF_FFFE};
            wr(8'h00, v);
            if (ok) exp_mode = mode_view(v);
            rd(8'h00, v); chk("R1 random mode write", v, exp_mode);
        end
        wr(8'h00, 32'h2200_0000);

        // R2 length key, random
        exp_len = 32'd0;
        for (int i = 0; i < 24; i++) begin
            logic ok;
            logic [4:0] k;
            ok = $urandom_range(0, 1) == 1;
            k  = ok ? 5'h08 : 5'h08 ^ 5'($urandom_range(1, 31));
            v  = {27'($urandom()), k};
            wr(8'h04, v);
            if (ok) exp_len = len_view(v);
            rd(8'h04, v); chk("R2 random length write", v, exp_len);
        end

        // R3 R5 R10: timeout to reset, pin active high
        wr(8'h00, 32'h2200_0006);
        wr(8'h04, (32'd3 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0007);
        cyc(tmo(3) - 1);
        chk("R3 no reset before expiry", {31'd0, sys_rst}, 32'd0);
        chk("R10 pin inactive low", {31'd0, ext_rst}, 32'd0);
        cyc(1);
        chk("R3 reset at expiry", {31'd0, sys_rst}, 32'd1);
        chk("R10 pin active high", {31'd0, ext_rst}, 32'd1);
        cyc(RSTT - 1);
        chk("R5 pulse still high", {31'd0, sys_rst}, 32'd1);
        cyc(1);
        chk("R5 pulse ended", {31'd0, sys_rst}, 32'd0);
        rd(8'h00, v); chk("R5 enable cleared", v, 32'h0000_0006);
        cyc(20);
        chk("R5 idle after pulse", {31'd0, sys_rst}, 32'd0);

        // R3 length zero acts as one
        wr(8'h04, 32'h0000_0008);
        wr(8'h00, 32'h2200_0001);
        cyc(tmo(0) - 1);
        chk("R3 len0 before", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R3 len0 expiry", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);

        // R4 kick reloads, bad kick ignored
        wr(8'h04, (32'd2 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0001);
        cyc(2);
        wr(8'h08, KICK());
        wr(8'h08, 32'h0000_1970);
        cyc(tmo(2) - 2);
        chk("R4 reload postponed expiry", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R4 expiry counted from kick", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);

        // R6 software reset while disabled, pin active low
        wr(8'h00, 32'h2200_0004);
        wr(8'h14, 32'h0000_1208);
        chk("R6 wrong value ignored", {31'd0, sys_rst}, 32'd0);
        chk("R10 pin idle high", {31'd0, ext_rst}, 32'd1);
        wr(8'h14, 32'h0000_1209);
        chk("R6 immediate reset", {31'd0, sys_rst}, 32'd1);
        chk("R10 pin active low", {31'd0, ext_rst}, 32'd0);
        cyc(RSTT - 1);
        chk("R6 pulse length", {31'd0, sys_rst}, 32'd1);
        cyc(1);
        chk("R6 pulse end", {31'd0, sys_rst}, 32'd0);
        chk("R10 pin released", {31'd0, ext_rst}, 32'd1);

        // R7 interrupt mode
        wr(8'h04, (32'd1 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0009);
        cyc(tmo(1) - 1);
        chk("R7 irq before expiry", {31'd0, irq}, 32'd0);
        cyc(1);
        chk("R7 irq at expiry", {31'd0, irq}, 32'd1);
        cyc(10);
        chk("R7 irq held", {31'd0, irq}, 32'd1);
        chk("R7 no reset in irq mode", {31'd0, sys_rst}, 32'd0);
        wr(8'h08, KICK());
        chk("R7 kick clears irq", {31'd0, irq}, 32'd0);
        cyc(tmo(1) - 1);
        chk("R7 irq before second expiry", {31'd0, irq}, 32'd0);
        cyc(1);
        chk("R7 irq again", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'h2200_0008);
        chk("R7 disable clears irq", {31'd0, irq}, 32'd0);

        // R8 two-stage without kick
        wr(8'h04, (32'd2 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0049);
        cyc(tmo(2));
        chk("R8 stage one irq", {31'd0, irq}, 32'd1);
        chk("R8 stage one no reset", {31'd0, sys_rst}, 32'd0);
        cyc(tmo(2) - 1);
        chk("R8 before stage two", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R8 stage two reset", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);
        chk("R8 irq cleared by pulse end", {31'd0, irq}, 32'd0);

        // R8 two-stage with kick between stages
        wr(8'h00, 32'h2200_0049);
        cyc(tmo(2));
        chk("R8 irq raised", {31'd0, irq}, 32'd1);
        wr(8'h08, KICK());
        chk("R8 kick clears irq", {31'd0, irq}, 32'd0);
        cyc(tmo(2) - 1);
        chk("R8 quiet after kick", {31'd0, irq | sys_rst}, 32'd0);
        cyc(1);
        chk("R8 back at stage one irq", {31'd0, irq}, 32'd1);
        chk("R8 back at stage one no reset", {31'd0, sys_rst}, 32'd0);
        cyc(tmo(2));
        chk("R8 then reset", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);

        // R9 disable stops count, enable restarts full length
        wr(8'h00, 32'h2200_0001);
        cyc(3);
        wr(8'h00, 32'h2200_0000);
        cyc(30);
        chk("R9 stopped no reset", {31'd0, sys_rst}, 32'd0);
        wr(8'h00, 32'h2200_0001);
        cyc(tmo(2) - 1);
        chk("R9 full length before", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R9 full length at", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);

        // R11 auto-restart
        wr(8'h04, (32'd1 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0011);
        cyc(tmo(1) + RSTT);
        chk("R11 pulse ended", {31'd0, sys_rst}, 32'd0);
        rd(8'h00, v); chk("R11 enable kept", v, 32'h0000_0011);
        cyc(tmo(1) - 1);
        chk("R11 reloaded before", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R11 reloaded expiry", {31'd0, sys_rst}, 32'd1);
        wr(8'h00, 32'h2200_0000);
        cyc(RSTT + 10);
        chk("R11 off after disable", {31'd0, sys_rst}, 32'd0);

        // R12 tick gating
        tick = 1'b0;
        wr(8'h00, 32'h2200_0001);
        cyc(30);
        chk("R12 frozen without tick", {31'd0, sys_rst}, 32'd0);
        tick = 1'b1;
        cyc(tmo(1) - 1);
        chk("R12 count resumes before", {31'd0, sys_rst}, 32'd0);
        cyc(1);
        chk("R12 count resumes at", {31'd0, sys_rst}, 32'd1);
        cyc(RSTT);

        // R3 random lengths
        for (int i = 0; i < 6; i++) begin
            int l;
            l = $urandom_range(1, 6);
            wr(8'h04, (32'(l) << 5) | 32'h08);
            wr(8'h00, 32'h2200_0001);
            cyc(tmo(l) - 1);
            chk("R3 random before", {31'd0, sys_rst}, 32'd0);
            cyc(1);
            chk("R3 random at", {31'd0, sys_rst}, 32'd1);
            cyc(RSTT);
            chk("R5 random pulse end", {31'd0, sys_rst}, 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [31:0] KICK();
        return 32'h0000_1971;
    endfunction

endmodule